// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a virtual address into a physical address by reading translation tables that live in memory. A request carries up to three table indices (a first segment index, a second segment index and a page index), an in-page offset and a two-bit mode. The walker starts at a table base register and makes one dependent memory read per table level. It then forms the physical address from the last entry read and the offset, or it stops with a fault code as soon as an entry is marked not resident.

Four modes are supported. Flat paging makes one read and concatenates the frame with the offset. Pure segmentation makes one read and adds the offset to a segment base. Paged segmentation makes two reads. Two-level segmentation with paging makes three reads. Each table entry is one memory word: the top bit is the resident flag and the remaining bits hold a frame number or the base address of the next table.

The walker handles one translation at a time. It waits any number of cycles for the memory to accept a read and for the data to come back. The table base register can be changed only while the walker is idle.

Top module: `xlate_walker`

## Requirements
- R1: During and right after reset, `reqReady` is 1, `resValid` is 0 and `memReqValid` is 0.
- R2: Mode 0 (flat paging) makes one read at `tbr + reqPage`. A resident entry with value V gives `resPaddr = {V, reqOff}`.
- R3: Mode 1 (pure segment) makes one read at `tbr + reqSeg1`. A resident entry with value V gives `resPaddr = V + reqOff`, formed as an arithmetic sum.
- R4: Mode 2 (paged segment) reads `tbr + reqSeg1` to get V1, then reads `V1 + reqPage` to get V2, and gives `resPaddr = {V2, reqOff}`.
- R5: Mode 3 (two-level segment) reads `tbr + reqSeg1`, then `V1 + reqSeg2`, then `V2 + reqPage`, and gives `resPaddr = {V3, reqOff}`.
- R6: A memory word whose bit DATA_W-1 is 0 ends the walk at once, with no further reads. The result then has status 2 (segment fault) in mode 1 and status 1 (page fault) in every other mode. `resLevel` gives the 1-based level of the faulting read, and `resPaddr` is 0.
- R7: A successful walk reports status 0 and `resLevel` 0.
- R8: `reqReady` is low from the cycle after a request is accepted until the result. Requests presented while the walker is busy are ignored. `resValid` is a single-cycle pulse, and `reqReady` is high again in the cycle after it.
- R9: `memReqValid` and `memReqAddr` stay steady until `memReqReady` is seen. The walker then waits any number of cycles for `memRspValid`.
- R10: A table base write is taken only while `reqReady` is 1 and is dropped otherwise. A request accepted in the same cycle as a write still walks from the previous base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tbrWe | input | 1 | Table base write strobe |
| tbrData | input | MAW | New table base |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and able to accept |
| reqMode | input | 2 | 0 flat page, 1 pure segment, 2 paged segment, 3 two-level segment |
| reqSeg1 | input | S1W | First segment index |
| reqSeg2 | input | S2W | Second segment index |
| reqPage | input | PW | Page index |
| reqOff | input | WW | In-page offset |
| memReqValid | output | 1 | Table read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | MAW | Table word address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | DATA_W | Table entry: resident flag in the top bit, value below it |
| resValid | output | 1 | Result pulse |
| resStatus | output | 2 | 0 ok, 1 page fault, 2 segment fault |
| resLevel | output | 2 | Faulting level (1 to 3), 0 when ok |
| resPaddr | output | DATA_W-1+WW | Physical address, 0 on a fault |

## Verification
Each mode is swept over its index fields, with offsets at 0, at the all-ones value and at values in between. The all-ones offset in mode 1 separates addition from concatenation, because the sum carries into the frame bits. Faults are placed at every level that each mode reaches, which checks the status code for each mode, the level reported and that no read follows the fault. The sweeps are repeated with a memory that stalls requests and delays responses, with junk requests and base writes arriving while the walker is busy, and with a base write in the same cycle as a request being accepted.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    MODE_PAGE   = 2'd0,
    MODE_SEG    = 2'd1,
    MODE_PSEG   = 2'd2,
    MODE_TWOSEG = 2'd3
  } walkMode_e;

  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_PAGE_FAULT = 2'd1,
    ST_SEG_FAULT  = 2'd2
  } walkStatus_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       tbrOpen;   // base register may be written
    logic       accept;    // latch request fields
    logic       capture;   // resident entry arrived
    logic       fault;     // non-resident entry arrived
    logic       compose;   // form the physical address
    logic [1:0] level;     // current table level, 1-based
  } ctrlStrobe_t;

  function automatic logic [1:0] levelsFor(walkMode_e m);
    case (m)
      MODE_PSEG:   return 2'd2;
      MODE_TWOSEG: return 2'd3;
      default:     return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int S1W    = 4,
  parameter int S2W    = 4,
  parameter int PW     = 4,
  parameter int WW     = 6,
  parameter int DATA_W = 16,
  parameter int MAW    = 16,
  localparam int VW    = DATA_W - 1,
  localparam int PAW   = VW + WW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              tbrWe,
  input  logic [MAW-1:0]    tbrData,
  input  logic [1:0]        reqMode,
  input  logic [S1W-1:0]    reqSeg1,
  input  logic [S2W-1:0]    reqSeg2,
  input  logic [PW-1:0]     reqPage,
  input  logic [WW-1:0]     reqOff,
  input  logic [DATA_W-1:0] memRspData,
  output logic [MAW-1:0]    memReqAddr,
  output logic              rspResident,
  output logic [1:0]        walkLevels,
  output logic [1:0]        resStatus,
  output logic [1:0]        resLevel,
  output logic [PAW-1:0]    resPaddr
);

  logic [MAW-1:0] tbrQ, baseQ, idx;
  walkMode_e      modeQ;
  logic [S1W-1:0] seg1Q;
  logic [S2W-1:0] seg2Q;
  logic [PW-1:0]  pageQ;
  logic [WW-1:0]  offQ;
  logic [VW-1:0]  entryQ, rspValue;
  logic [PAW-1:0] paddrQ, paddrCat, paddrSum;
  walkStatus_e    statusQ;
  logic [1:0]     levelQ;

  assign rspResident = memRspData[DATA_W-1];
  assign rspValue    = memRspData[VW-1:0];
  assign walkLevels  = levelsFor(modeQ);

  // index used at the current level
  always_comb begin
    case (modeQ)
      MODE_PAGE: idx = MAW'(pageQ);
      MODE_SEG:  idx = MAW'(seg1Q);
      MODE_PSEG: idx = (strobe.level == 2'd1) ? MAW'(seg1Q) : MAW'(pageQ);
      default: begin
        case (strobe.level)
          2'd1:    idx = MAW'(seg1Q);
          2'd2:    idx = MAW'(seg2Q);
          default: idx = MAW'(pageQ);
        endcase
      end
    endcase
  end

  assign memReqAddr = baseQ + idx;

  assign paddrCat = {entryQ, offQ};
  assign paddrSum = PAW'(entryQ) + PAW'(offQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tbrQ    <= '0;
      baseQ   <= '0;
      modeQ   <= MODE_PAGE;
      seg1Q   <= '0;
      seg2Q   <= '0;
      pageQ   <= '0;
      offQ    <= '0;
      entryQ  <= '0;
      paddrQ  <= '0;
      statusQ <= ST_OK;
      levelQ  <= '0;
    end else begin
      if (strobe.tbrOpen && tbrWe) tbrQ <= tbrData;
      if (strobe.accept) begin
        baseQ   <= tbrQ;
        modeQ   <= walkMode_e'(reqMode);
        seg1Q   <= reqSeg1;
        seg2Q   <= reqSeg2;
        pageQ   <= reqPage;
        offQ    <= reqOff;
        paddrQ  <= '0;
        statusQ <= ST_OK;
        levelQ  <= '0;
      end
      if (strobe.capture) begin
        baseQ  <= MAW'(rspValue);
        entryQ <= rspValue;
      end
      if (strobe.fault) begin
        statusQ <= (modeQ == MODE_SEG) ? ST_SEG_FAULT : ST_PAGE_FAULT;
        levelQ  <= strobe.level;
      end
      if (strobe.compose) paddrQ <= (modeQ == MODE_SEG) ? paddrSum : paddrCat;
    end
  end

  assign resStatus = statusQ;
  assign resLevel  = levelQ;
  assign resPaddr  = paddrQ;

  // R6: a segment fault is only ever recorded for a pure segment walk
  assert_seg_fault_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusQ == ST_SEG_FAULT |-> modeQ == MODE_SEG);

  // R6: the recorded fault level never exceeds the depth of the mode
  assert_fault_depth_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusQ != ST_OK |-> levelQ >= 2'd1 && levelQ <= walkLevels);

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        rspResident,
  input  logic [1:0]  walkLevels,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        resValid
);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_COMPOSE, S_DONE
  } walkState_e;

  walkState_e stateQ;
  logic [1:0] levelQ;
  logic       rspHere;

  assign rspHere     = (stateQ == S_WAIT) && memRspValid;
  assign reqReady    = (stateQ == S_IDLE);
  assign memReqValid = (stateQ == S_ISSUE);
  assign resValid    = (stateQ == S_DONE);

  always_comb begin
    strobe         = '0;
    strobe.tbrOpen = (stateQ == S_IDLE);
    strobe.accept  = (stateQ == S_IDLE) && reqValid;
    strobe.capture = rspHere && rspResident;
    strobe.fault   = rspHere && !rspResident;
    strobe.compose = (stateQ == S_COMPOSE);
    strobe.level   = levelQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      levelQ <= '0;
    end else begin
      case (stateQ)
        S_IDLE: if (reqValid) begin
          stateQ <= S_ISSUE;
          levelQ <= 2'd1;
        end
        S_ISSUE: if (memReqReady) stateQ <= S_WAIT;
        S_WAIT: if (memRspValid) begin
          if (!rspResident)              stateQ <= S_DONE;
          else if (levelQ == walkLevels) stateQ <= S_COMPOSE;
          else begin
            stateQ <= S_ISSUE;
            levelQ <= levelQ + 2'd1;
          end
        end
        S_COMPOSE: stateQ <= S_DONE;
        default: begin
          stateQ <= S_IDLE;
          levelQ <= '0;
        end
      endcase
    end
  end

  // R8: result is a single-cycle pulse
  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R8: after the result the walker is ready again
  assert_ready_after_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> reqReady);

  // R1: an idle walker never reads memory
  assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid);

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int S1W    = 4,
  parameter int S2W    = 4,
  parameter int PW     = 4,
  parameter int WW     = 6,
  parameter int DATA_W = 16,
  parameter int MAW    = 16,
  localparam int PAW   = DATA_W - 1 + WW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tbrWe,
  input  logic [MAW-1:0]    tbrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqMode,
  input  logic [S1W-1:0]    reqSeg1,
  input  logic [S2W-1:0]    reqSeg2,
  input  logic [PW-1:0]     reqPage,
  input  logic [WW-1:0]     reqOff,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [MAW-1:0]    memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              resValid,
  output logic [1:0]        resStatus,
  output logic [1:0]        resLevel,
  output logic [PAW-1:0]    resPaddr
);

  ctrlStrobe_t strobe;
  logic        rspResident;
  logic [1:0]  walkLevels;

  xlate_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspResident (rspResident),
    .walkLevels  (walkLevels),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .resValid    (resValid)
  );

  xlate_dpath #(
    .S1W(S1W), .S2W(S2W), .PW(PW), .WW(WW), .DATA_W(DATA_W), .MAW(MAW)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .tbrWe       (tbrWe),
    .tbrData     (tbrData),
    .reqMode     (reqMode),
    .reqSeg1     (reqSeg1),
    .reqSeg2     (reqSeg2),
    .reqPage     (reqPage),
    .reqOff      (reqOff),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .rspResident (rspResident),
    .walkLevels  (walkLevels),
    .resStatus   (resStatus),
    .resLevel    (resLevel),
    .resPaddr    (resPaddr)
  );

  // R9: a pending read holds its address until accepted
  assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R6: a faulted result carries no address and a level
  assert_fault_no_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resStatus != 2'd0 |-> resPaddr == '0 && resLevel != 2'd0);

  // R7: a good result reports level zero
  assert_ok_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resStatus == 2'd0 |-> resLevel == 2'd0);

endmodule

// File: tb/xlate_walker_bench.sv
`timescale 1ns/1ps
module xlate_walker_bench;

  localparam int S1W = 4, S2W = 4, PW = 4, WW = 6, DATA_W = 16, MAW = 16;
  localparam int PAW = DATA_W - 1 + WW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tbrWe = 1'b0;
  logic [MAW-1:0] tbrData = '0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqMode = '0;
  logic [S1W-1:0] reqSeg1 = '0;
  logic [S2W-1:0] reqSeg2 = '0;
  logic [PW-1:0] reqPage = '0;
  logic [WW-1:0] reqOff = '0;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic [MAW-1:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [DATA_W-1:0] memRspData = '0;
  logic resValid;
  logic [1:0] resStatus, resLevel;
  logic [PAW-1:0] resPaddr;

  always #2.5 clk = ~clk;

  xlate_walker #(.S1W(S1W), .S2W(S2W), .PW(PW), .WW(WW), .DATA_W(DATA_W), .MAW(MAW))
  u_xlate_walker (
    .clk(clk), .rstN(rstN), .tbrWe(tbrWe), .tbrData(tbrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqMode(reqMode),
    .reqSeg1(reqSeg1), .reqSeg2(reqSeg2), .reqPage(reqPage), .reqOff(reqOff),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .resValid(resValid), .resStatus(resStatus), .resLevel(resLevel), .resPaddr(resPaddr)
  );

  int checks = 0;
  int failures = 0;
  int seed = 11;
  int latency = 0;
  int readyMod = 1;
  int faultAddr = -1;
  int tbrModel = 0;
  int logAddr [4];
  int logCount = 0;
  bit modelOn = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int valFn(int addr);
    return ((addr * 37 + seed) ^ (addr >> 3)) & 32'h7fff;
  endfunction

  // memory model: stalls, delays and fault injection
  initial begin
    int negCount = 0;
    bit acceptNext = 0;
    bit rspPending = 0;
    int rspDelay = 0;
    int rspAddr = 0;
    int heldAddr = 0;
    bit prevStall = 0;
    int prevAddr = 0;
    forever begin
      @(negedge clk);
      negCount++;
      memRspValid = 1'b0;
      if (acceptNext) begin
        rspPending = 1; rspDelay = latency; rspAddr = heldAddr; acceptNext = 0;
      end
      if (rspPending) begin
        if (rspDelay == 0) begin
          memRspValid = 1'b1;
          memRspData = DATA_W'(((rspAddr == faultAddr) ? 0 : 32'h8000) | valFn(rspAddr));
          rspPending = 0;
        end else rspDelay--;
      end
      if (modelOn && prevStall)
        check(memReqValid && int'(memReqAddr) == prevAddr, "R9", "held request addr",
              int'(memReqAddr), prevAddr);
      memReqReady = ((negCount % readyMod) == 0);
      prevStall = memReqValid && !memReqReady;
      prevAddr = int'(memReqAddr);
      if (memReqValid && memReqReady) begin
        acceptNext = 1; heldAddr = int'(memReqAddr);
        if (logCount < 4) logAddr[logCount] = heldAddr;
        logCount++;
      end
    end
  end

  task automatic setTbr(int v);
    @(negedge clk);
    tbrWe = 1'b1; tbrData = MAW'(v);
    @(negedge clk);
    tbrWe = 1'b0;
    tbrModel = v;
  endtask

  // one translation; newTbr >= 0 writes the base in the accept cycle
  task automatic runWalk(int mode, int s1, int s2, int p, int w, int faultLvl, bit jam, int newTbr);
    int lv, base, expLevel, expReads, expStatus, expPaddr, cyc, v;
    int idx [3];
    int addrs [3];
    string tag;
    tag = (mode == 0) ? "R2" : (mode == 1) ? "R3" : (mode == 2) ? "R4" : "R5";
    lv = (mode <= 1) ? 1 : (mode == 2) ? 2 : 3;
    idx[0] = (mode == 0) ? p : s1;
    idx[1] = (mode == 3) ? s2 : p;
    idx[2] = p;
    base = tbrModel;
    for (int l = 0; l < lv; l++) begin
      addrs[l] = base + idx[l];
      base = valFn(addrs[l]);
    end
    faultAddr = (faultLvl > 0) ? addrs[faultLvl-1] : -1;
    expLevel = 0;
    for (int l = lv - 1; l >= 0; l--) if (addrs[l] == faultAddr) expLevel = l + 1;
    expReads = (expLevel != 0) ? expLevel : lv;
    v = valFn(addrs[lv-1]);
    expStatus = (expLevel == 0) ? 0 : (mode == 1) ? 2 : 1;
    expPaddr = (expLevel != 0) ? 0 : (mode == 1) ? v + w : v * (1 << WW) + w;

    @(negedge clk);
    check(reqReady == 1'b1, "R8", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqMode = 2'(mode);
    reqSeg1 = S1W'(s1); reqSeg2 = S2W'(s2); reqPage = PW'(p); reqOff = WW'(w);
    if (newTbr >= 0) begin tbrWe = 1'b1; tbrData = MAW'(newTbr); end
    logCount = 0;
    @(negedge clk);
    tbrWe = 1'b0;
    reqValid = jam;
    if (jam) begin
      reqMode = 2'(mode ^ 3); reqSeg1 = S1W'(~s1); reqPage = PW'(~p); reqOff = WW'(~w);
      tbrWe = 1'b1; tbrData = MAW'(16'h2345);
    end
    check(reqReady == 1'b0, "R8", "busy after accept", int'(reqReady), 0);
    cyc = 0;
    while (!resValid && cyc < 300) begin @(negedge clk); cyc++; end
    reqValid = 1'b0; tbrWe = 1'b0;
    check(resValid == 1'b1, tag, "result arrived", int'(resValid), 1);
    check(int'(resStatus) == expStatus, (expLevel != 0) ? "R6" : "R7", "status",
          int'(resStatus), expStatus);
    check(int'(resLevel) == expLevel, (expLevel != 0) ? "R6" : "R7", "level",
          int'(resLevel), expLevel);
    check(int'(resPaddr) == expPaddr, (expLevel != 0) ? "R6" : tag, "paddr",
          int'(resPaddr), expPaddr);
    check(logCount == expReads, (expLevel != 0) ? "R6" : tag, "read count", logCount, expReads);
    for (int l = 0; l < expReads && l < logCount; l++)
      check(logAddr[l] == addrs[l], (newTbr >= 0 || jam) ? "R10" : tag, "read addr",
            logAddr[l], addrs[l]);
    @(negedge clk);
    check(resValid == 1'b0, "R8", "pulse ends", int'(resValid), 0);
    check(reqReady == 1'b1, "R8", "ready again", int'(reqReady), 1);
    faultAddr = -1;
    if (newTbr >= 0) tbrModel = newTbr;
  endtask

  task automatic sweep(bit jam);
    for (int p = 0; p < 16; p++) begin
      runWalk(0, 0, 0, p, 0, 0, jam, -1);
      runWalk(0, 0, 0, p, 63, 0, jam, -1);
    end
    for (int s = 0; s < 16; s++) begin
      runWalk(1, s, 0, 0, 63, 0, jam, -1);
      runWalk(1, s, 0, 0, s * 4, 0, jam, -1);
    end
    for (int s = 0; s < 16; s++) runWalk(2, s, 0, 15 - s, s + 17, 0, jam, -1);
    for (int a = 0; a < 16; a += 5)
      for (int b = 0; b < 16; b += 5)
        for (int c = 0; c < 16; c += 5)
          runWalk(3, a, b, c, a * 3 + c, 0, jam, -1);
  endtask

  task automatic faults(bit jam);
    for (int m = 0; m < 4; m++) begin
      int lv = (m <= 1) ? 1 : (m == 2) ? 2 : 3;
      for (int f = 1; f <= lv; f++) runWalk(m, 3, 7, 9, 21, f, jam, -1);
    end
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(reqReady == 1'b1, "R1", "reqReady in reset", int'(reqReady), 1);
        check(resValid == 1'b0, "R1", "resValid in reset", int'(resValid), 0);
        check(memReqValid == 1'b0, "R1", "memReqValid in reset", int'(memReqValid), 0);
        rstN = 1'b1;
        @(negedge clk);
        check(reqReady == 1'b1 && memReqValid == 1'b0, "R1", "after reset",
              int'(memReqValid), 0);
        modelOn = 1'b1;
        setTbr(16'h0100);
        sweep(0);
        faults(0);
        // stalls and latency, busy-time junk requests and base writes (R9, R10)
        seed = 977; latency = 3; readyMod = 3;
        sweep(1);
        faults(1);
        seed = 4099; latency = 1; readyMod = 2;
        // R10: same-cycle write walks from old base, next walk uses new
        runWalk(2, 5, 0, 6, 10, 0, 0, 16'h0400);
        runWalk(2, 5, 0, 6, 10, 0, 0, -1);
        runWalk(3, 1, 2, 3, 4, 0, 1, -1);
        done = 1;
      end
      begin
        repeat (150000) @(negedge clk);
        if (!done) check(1'b0, "R8", "watchdog expired", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule